// File: doc/BRIEF.md
# Block Cipher Register Front-End with Chaining Modes

This block is the software-facing side of a 128-bit block cipher engine. Through a simple word-wide register port, software loads a key of 128, 192 or 256 bits, an initialization vector and one block of input data. It selects a chaining mode and a direction, then polls a busy bit and reads the result. The cipher rounds are not part of this block. It hands one 128-bit block at a time to an external primitive over a request/acknowledge port. It applies the ECB, CBC, OFB, CFB or CTR feedback around that primitive.

Feedback state stays in the IV registers between blocks. A message can therefore be processed block after block without reloading the IV, and software can read the chain state back at any time. Writing input word 0 launches an operation. While it runs, every register write is dropped, so configuration cannot change in the middle of a block.

Address map (word addresses): 0x00 control, 0x04..0x07 IV words 0..3, 0x08..0x0B input words 0..3, 0x0C..0x0F output words 0..3 (read-only), 0x10..0x17 key words 0..7 (write-only, read 0). Control bits: [2:0] mode, [3] direction, [5:4] key size, [6] prepare-decrypt-key, [7] busy (read-only), [8] key valid (read-only). In every 128-bit value, word 3 is bits 127:96 and holds the first word of the stream; word 0 is bits 31:0.

Top module: `aes_fe_top`

## Requirements
- R1: The key-size field (control bits 5:4) takes 0, 1 or 2 for 128, 192 and 256 bit keys. Code 3 refuses a start, and busy stays 0.
- R2: A key of size code s uses key registers 0 to 3+2s, with the first key word in the highest of those registers. On key_o, word i sits at bits 32i+31:32i, and words above the used range are driven as zero, so stale values there have no effect.
- R3: The mode field (control bits 2:0) selects 0 ECB, 1 CBC, 2 OFB, 3 CFB, 4 CTR. Codes 5 to 7 refuse a start, and busy stays 0.
- R4: After reset, control, IV and output registers read 0. A write to input word 0 (0x08) while idle, with a valid configuration, sets busy (control bit 7) from the next cycle. req_o is held until ack_i, and busy falls on the same edge at which the output registers take the result.
- R5: ECB sends the input block to the primitive with dir_o equal to the direction bit (0 encrypt, 1 decrypt). The output is the primitive's result, and the feedback is unchanged.
- R6: CBC encryption sends input XOR feedback forward, and the output becomes the new feedback. CBC decryption sends the input in reverse direction, outputs result XOR old feedback, and keeps the input as the new feedback.
- R7: OFB sends the feedback forward, outputs result XOR input, and keeps the result as the new feedback, for either direction bit.
- R8: CFB sends the feedback forward and outputs result XOR input. The new feedback is the ciphertext: the output when encrypting and the input when decrypting.
- R9: CTR sends the feedback forward and outputs result XOR input. Afterwards the low 32 bits of the feedback are incremented modulo 2^32, and the upper 96 bits are kept.
- R10: The IV registers read back the current feedback. A following block without an IV reload continues from it.
- R11: While busy is 1, writes to any register (key, IV, control, input) are dropped.
- R12: A start in ECB or CBC decryption is refused unless the prepare-decrypt-key bit is set or key valid (control bit 8) is 1. Key valid is set when a block completes with the prepare bit set, and is cleared by any key write or key-size change. Encryption is never gated.
- R13: While req_o is 1 and ack_i is 0, req_o and blk_o stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | W | Write data |
| rdata_o | output | W | Read data for addr_i (combinational) |
| req_o | output | 1 | Request to the cipher primitive |
| ack_i | input | 1 | Primitive result valid, accepted this cycle |
| blk_o | output | W*NBLK | Block presented to the primitive |
| dir_o | output | 1 | Primitive direction, 0 forward, 1 inverse |
| key_o | output | W*NKEY | Key words, unused words zero |
| ksz_o | output | 2 | Key-size code |
| prep_o | output | 1 | Prepare-decrypt-key request |
| res_i | input | W*NBLK | Primitive result |

## Verification
Busy is due in the cycle after the edge that takes the write to input word 0. A refused start shows busy still 0 at that same point. The output registers, the feedback and the fall of busy are all due on the edge at which ack_i is sampled high. The bench therefore drives and samples on the falling clock edge: it reads control once right after the start write, then polls busy and reads outputs and IV words only after busy has dropped. The stand-in primitive acknowledges after a chosen number of cycles. For the test that writes while busy, this number is raised so that every intruding write falls inside the busy window.

// File: rtl/aes_fe_pkg.sv
package aes_fe_pkg;
  typedef enum logic [2:0] {
    M_ECB = 3'd0,
    M_CBC = 3'd1,
    M_OFB = 3'd2,
    M_CFB = 3'd3,
    M_CTR = 3'd4
  } mode_e;

  localparam int A_CTRL = 0;
  localparam int A_IV   = 4;
  localparam int A_IN   = 8;
  localparam int A_OUT  = 12;
  localparam int A_KEY  = 16;

  localparam logic [1:0] KSZ_MAX = 2'd2;
endpackage

// File: rtl/aes_fe_regs.sv
module aes_fe_regs
  import aes_fe_pkg::*;
#(
  parameter int W      = 32,
  parameter int NKEY   = 8,
  parameter int NBLK   = 4,
  parameter int ADDR_W = 5,
  localparam int KI_W  = $clog2(NKEY),
  localparam int BI_W  = $clog2(NBLK)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [W-1:0]         wdata_i,
  input  logic                 busy_i,
  output logic [NKEY*W-1:0]    key_o,
  output logic [2:0]           mode_o,
  output logic                 dir_o,
  output logic [1:0]           ksz_o,
  output logic                 prep_o,
  output logic [NBLK*W-1:0]    din_q_o,
  output logic [NBLK*W-1:0]    din_eff_o,
  output logic                 key_wr_o,
  output logic                 ksz_chg_o,
  output logic                 start_wr_o,
  output logic                 iv_we_o,
  output logic [BI_W-1:0]      iv_idx_o
);
  logic wr_ok, ctrl_wr;
  logic [ADDR_W-1:0] key_off, iv_off, in_off;

  assign wr_ok   = we_i && !busy_i;
  assign key_off = addr_i - ADDR_W'(A_KEY);
  assign iv_off  = addr_i - ADDR_W'(A_IV);
  assign in_off  = addr_i - ADDR_W'(A_IN);
  assign ctrl_wr = wr_ok && addr_i == ADDR_W'(A_CTRL);

  assign key_wr_o   = wr_ok && addr_i >= ADDR_W'(A_KEY) && key_off < ADDR_W'(NKEY);
  assign iv_we_o    = wr_ok && addr_i >= ADDR_W'(A_IV) && iv_off < ADDR_W'(NBLK);
  assign iv_idx_o   = BI_W'(iv_off);
  assign start_wr_o = wr_ok && addr_i == ADDR_W'(A_IN);
  assign ksz_chg_o  = ctrl_wr && wdata_i[5:4] != ksz_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= '0;
      dir_o  <= 1'b0;
      ksz_o  <= '0;
      prep_o <= 1'b0;
    end else if (ctrl_wr) begin
      mode_o <= wdata_i[2:0];
      dir_o  <= wdata_i[3];
      ksz_o  <= wdata_i[5:4];
      prep_o <= wdata_i[6];
    end
  end

  for (genvar i = 0; i < NKEY; i++) begin : g_key
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) key_o[i*W +: W] <= '0;
      else if (key_wr_o && KI_W'(key_off) == KI_W'(i)) key_o[i*W +: W] <= wdata_i;
    end
  end

  for (genvar i = 0; i < NBLK; i++) begin : g_din
    logic hit;
    assign hit = wr_ok && addr_i >= ADDR_W'(A_IN) && in_off < ADDR_W'(NBLK)
                 && BI_W'(in_off) == BI_W'(i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) din_q_o[i*W +: W] <= '0;
      else if (hit) din_q_o[i*W +: W] <= wdata_i;
    end
    // word 0 arrives with the start write itself
    assign din_eff_o[i*W +: W] = hit ? wdata_i : din_q_o[i*W +: W];
  end
endmodule

// File: rtl/aes_fe_chain.sv
module aes_fe_chain
  import aes_fe_pkg::*;
#(
  parameter int W    = 32,
  parameter int NBLK = 4,
  localparam int BW   = W*NBLK,
  localparam int BI_W = $clog2(NBLK)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_wr_i,
  input  logic [2:0]      mode_i,
  input  logic            dir_i,
  input  logic [1:0]      ksz_i,
  input  logic            prep_i,
  input  logic [BW-1:0]   din_q_i,
  input  logic [BW-1:0]   din_eff_i,
  input  logic            key_wr_i,
  input  logic            ksz_chg_i,
  input  logic            iv_we_i,
  input  logic [BI_W-1:0] iv_idx_i,
  input  logic [W-1:0]    wdata_i,
  input  logic            ack_i,
  input  logic [BW-1:0]   res_i,
  output logic            busy_o,
  output logic [BW-1:0]   blk_o,
  output logic            dir_o,
  output logic [BW-1:0]   out_o,
  output logic [BW-1:0]   fb_o,
  output logic            kv_o
);
  logic          go, cfg_ok, need_kv, done;
  logic [BW-1:0] cin, out_nx, fb_nx;
  logic          cdir;

  assign need_kv = dir_i && (mode_i == M_ECB || mode_i == M_CBC);
  assign cfg_ok  = mode_i <= M_CTR && ksz_i <= KSZ_MAX && !(need_kv && !kv_o && !prep_i);
  assign go      = start_wr_i && cfg_ok;
  assign done    = busy_o && ack_i;

  // primitive input at start
  always_comb begin
    cin  = fb_o;
    cdir = 1'b0;
    unique case (mode_i)
      M_ECB: begin cin = din_eff_i; cdir = dir_i; end
      M_CBC: begin cin = dir_i ? din_eff_i : (din_eff_i ^ fb_o); cdir = dir_i; end
      default: ;
    endcase
  end

  // result and next feedback at completion
  always_comb begin
    out_nx = res_i ^ din_q_i;
    fb_nx  = fb_o;
    unique case (mode_i)
      M_ECB: out_nx = res_i;
      M_CBC: begin
        out_nx = dir_i ? (res_i ^ fb_o) : res_i;
        fb_nx  = dir_i ? din_q_i : res_i;
      end
      M_OFB: fb_nx = res_i;
      M_CFB: fb_nx = dir_i ? din_q_i : (res_i ^ din_q_i);
      M_CTR: fb_nx = {fb_o[BW-1:W], fb_o[W-1:0] + W'(1)};
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      blk_o  <= '0;
      dir_o  <= 1'b0;
      out_o  <= '0;
    end else if (done) begin
      busy_o <= 1'b0;
      out_o  <= out_nx;
    end else if (go && !busy_o) begin
      busy_o <= 1'b1;
      blk_o  <= cin;
      dir_o  <= cdir;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fb_o <= '0;
    else if (done) fb_o <= fb_nx;
    else if (iv_we_i) fb_o[iv_idx_i*W +: W] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) kv_o <= 1'b0;
    else if (key_wr_i || ksz_chg_i) kv_o <= 1'b0;
    else if (done && prep_i) kv_o <= 1'b1;
  end
endmodule

// File: rtl/aes_fe_top.sv
module aes_fe_top
  import aes_fe_pkg::*;
#(
  parameter int W      = 32,
  parameter int NKEY   = 8,
  parameter int NBLK   = 4,
  parameter int ADDR_W = 5,
  localparam int BW    = W*NBLK,
  localparam int BI_W  = $clog2(NBLK),
  localparam int KMIN  = NKEY/2,
  localparam int KSTEP = NKEY/4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  output logic              req_o,
  input  logic              ack_i,
  output logic [BW-1:0]     blk_o,
  output logic              dir_o,
  output logic [NKEY*W-1:0] key_o,
  output logic [1:0]        ksz_o,
  output logic              prep_o,
  input  logic [BW-1:0]     res_i
);
  logic [NKEY*W-1:0] key_q;
  logic [2:0]        mode;
  logic              dir_cfg, kv, busy;
  logic [BW-1:0]     din_q, din_eff, out_q, fb;
  logic              key_wr, ksz_chg, start_wr, iv_we;
  logic [BI_W-1:0]   iv_idx;
  logic [ADDR_W-1:0] iv_off, out_off;

  aes_fe_regs #(.W(W), .NKEY(NKEY), .NBLK(NBLK), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .busy_i(busy), .key_o(key_q), .mode_o(mode), .dir_o(dir_cfg), .ksz_o, .prep_o,
    .din_q_o(din_q), .din_eff_o(din_eff), .key_wr_o(key_wr), .ksz_chg_o(ksz_chg),
    .start_wr_o(start_wr), .iv_we_o(iv_we), .iv_idx_o(iv_idx)
  );

  aes_fe_chain #(.W(W), .NBLK(NBLK)) u_chain (
    .clk_i, .rst_ni, .start_wr_i(start_wr), .mode_i(mode), .dir_i(dir_cfg),
    .ksz_i(ksz_o), .prep_i(prep_o), .din_q_i(din_q), .din_eff_i(din_eff),
    .key_wr_i(key_wr), .ksz_chg_i(ksz_chg), .iv_we_i(iv_we), .iv_idx_i(iv_idx),
    .wdata_i, .ack_i, .res_i, .busy_o(busy), .blk_o, .dir_o, .out_o(out_q),
    .fb_o(fb), .kv_o(kv)
  );

  assign req_o = busy;

  for (genvar i = 0; i < NKEY; i++) begin : g_kmask
    localparam int I = i;
    assign key_o[i*W +: W] = (I < KMIN + KSTEP*int'(ksz_o)) ? key_q[i*W +: W] : '0;
  end

  assign iv_off  = addr_i - ADDR_W'(A_IV);
  assign out_off = addr_i - ADDR_W'(A_OUT);

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(A_CTRL))
      rdata_o = W'({kv, busy, prep_o, ksz_o, dir_cfg, mode});
    else if (addr_i >= ADDR_W'(A_IV) && iv_off < ADDR_W'(NBLK))
      rdata_o = fb[BI_W'(iv_off)*W +: W];
    else if (addr_i >= ADDR_W'(A_OUT) && out_off < ADDR_W'(NBLK))
      rdata_o = out_q[BI_W'(out_off)*W +: W];
  end
endmodule

// File: rtl/aes_fe_chk.sv
module aes_fe_chk
  import aes_fe_pkg::*;
#(
  parameter int W      = 32,
  parameter int NKEY   = 8,
  parameter int NBLK   = 4,
  parameter int ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              busy,
  input logic              req_o,
  input logic              ack_i,
  input logic [W*NBLK-1:0] blk_o,
  input logic [2:0]        mode,
  input logic [1:0]        ksz_o,
  input logic [NKEY*W-1:0] key_q,
  input logic [W*NBLK-1:0] fb
);
  logic start_try;
  assign start_try = we_i && addr_i == ADDR_W'(A_IN) && !busy;

  p_bad_ksz_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_try && ksz_o == 2'd3 |=> !busy);
  p_bad_mode_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_try && mode > 3'd4 |=> !busy);
  p_ack_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && ack_i |=> !busy);
  p_ecb_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && ack_i && mode == M_ECB |=> $stable(fb));
  p_ctr_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && ack_i && mode == M_CTR |=> fb[W-1:0] == $past(fb[W-1:0]) + W'(1));
  p_key_frozen_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(key_q));
  p_iv_frozen_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && !ack_i |=> $stable(fb));
  p_req_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(blk_o));
endmodule

bind aes_fe_top aes_fe_chk #(.W(W), .NKEY(NKEY), .NBLK(NBLK), .ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .we_i, .addr_i, .busy, .req_o, .ack_i, .blk_o, .mode, .ksz_o,
  .key_q, .fb
);

// File: tb/sim_aes_fe_top.sv
`timescale 1ns/1ps
module sim_aes_fe_top;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic we = 0;
  logic [4:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic req, dir, prep, ack = 0;
  logic [127:0] blk, res = 0;
  logic [255:0] key;
  logic [1:0] ksz;

  aes_fe_top u0 (.clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .req_o(req), .ack_i(ack), .blk_o(blk), .dir_o(dir), .key_o(key),
    .ksz_o(ksz), .prep_o(prep), .res_i(res));

  int checks = 0, fails = 0, cyc = 0, lat = 3, rcnt = 0;
  logic [31:0] seed = 32'h1234_5678;

  // reversible stand-in: rotate left 8 then xor key fold; inverse undoes it
  function automatic logic [127:0] prim(input logic [127:0] x, input logic [127:0] k, input logic d);
    logic [127:0] y;
    if (!d) return {x[119:0], x[127:120]} ^ k;
    y = x ^ k;
    return {y[7:0], y[127:8]};
  endfunction

  always @(negedge clk) begin
    if (ack) begin ack <= 0; rcnt <= 0; end
    else if (req) begin
      if (rcnt >= lat) begin
        ack <= 1;
        res <= prim(blk, key[127:0] ^ key[255:128] ^ {126'b0, ksz}, dir);
      end else rcnt <= rcnt + 1;
    end
  end

  // reference model
  logic [31:0] km [8];
  logic [127:0] fb_m = 0, out_m = 0;
  logic [2:0] mode_m = 0;
  logic dir_m = 0, prep_m = 0, kv_m = 0;
  logic [1:0] ksz_m = 0;

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  function automatic logic [127:0] kfold();
    logic [255:0] kv;
    kv = 0;
    for (int i = 0; i < 8; i++) if (i < 4 + 2*int'(ksz_m)) kv[i*32 +: 32] = km[i];
    return kv[127:0] ^ kv[255:128] ^ {126'b0, ksz_m};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s got %h exp %h", tag, got, exp); end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = 5'(a); wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); addr = 5'(a); #1 d = rdata;
  endtask

  task automatic set_ctrl(input int m, input bit d, input int s, input bit p);
    logic [31:0] r;
    wr(0, {25'b0, p, 2'(s), d, 3'(m)});
    if (2'(s) != ksz_m) kv_m = 0;
    mode_m = 3'(m); dir_m = d; ksz_m = 2'(s); prep_m = p;
    rd(0, r);
    chk(r[6:0] == {p, 2'(s), d, 3'(m)}, "R1 ctrl fields", 128'(r[6:0]), 128'({p, 2'(s), d, 3'(m)}));
  endtask

  task automatic load_key(input int s);
    int nk;
    nk = 4 + 2*s;
    for (int i = 0; i < nk; i++) begin
      logic [31:0] w;
      w = rnd();
      wr(16 + nk - 1 - i, w);    // first word into highest register used
      km[nk - 1 - i] = w;
    end
    kv_m = 0;
  endtask

  task automatic load_iv(input logic [127:0] v);
    for (int i = 3; i >= 0; i--) wr(4 + i, v[i*32 +: 32]);
    fb_m = v;
  endtask

  task automatic run(input logic [127:0] din, input string tag, input bit meddle);
    logic [31:0] r;
    logic [127:0] got, k, c, o, f;
    bit ok;
    int n;
    ok = mode_m <= 4 && ksz_m <= 2 && !(dir_m && mode_m <= 1 && !kv_m && !prep_m);
    o = out_m; f = fb_m;
    if (ok) begin
      k = kfold();
      case (mode_m)
        3'd0: o = prim(din, k, dir_m);
        3'd1: if (!dir_m) begin o = prim(din ^ fb_m, k, 0); f = o; end
              else begin o = prim(din, k, 1) ^ fb_m; f = din; end
        3'd2: begin c = prim(fb_m, k, 0); o = c ^ din; f = c; end
        3'd3: begin c = prim(fb_m, k, 0); o = c ^ din; f = dir_m ? din : o; end
        default: begin c = prim(fb_m, k, 0); o = c ^ din; f = {fb_m[127:32], fb_m[31:0] + 32'd1}; end
      endcase
    end
    for (int i = 3; i >= 0; i--) wr(8 + i, din[i*32 +: 32]);
    rd(0, r);
    chk(r[7] == ok, {tag, " R4 busy after start"}, 128'(r[7]), 128'(ok));
    if (meddle) begin
      wr(16, 32'hDEAD_0001); wr(4, 32'hDEAD_0002);
      wr(0, 32'h0000_0044); wr(9, 32'hDEAD_0003);
    end
    n = 0;
    do begin rd(0, r); n++; end while (r[7] && n < 200);
    chk(!r[7], {tag, " R4 busy clears"}, 128'(r[7]), 128'(0));
    if (meddle)
      chk(r[6:0] == {prep_m, ksz_m, dir_m, mode_m}, "R11 ctrl kept",
          128'(r[6:0]), 128'({prep_m, ksz_m, dir_m, mode_m}));
    for (int i = 0; i < 4; i++) begin rd(12 + i, r); got[i*32 +: 32] = r; end
    chk(got == o, {tag, " output"}, got, o);
    for (int i = 0; i < 4; i++) begin rd(4 + i, r); got[i*32 +: 32] = r; end
    chk(got == f, {tag, " R10 feedback"}, got, f);
    if (ok && prep_m) kv_m = 1;
    out_m = o; fb_m = f;
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  string nm [5] = '{"R5 ECB", "R6 CBC", "R7 OFB", "R8 CFB", "R9 CTR"};

  initial begin
    logic [31:0] r;
    for (int i = 0; i < 8; i++) km[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(0, r);  chk(r == 0, "R4 reset ctrl", 128'(r), 0);
    rd(12, r); chk(r == 0, "R4 reset out", 128'(r), 0);
    rd(7, r);  chk(r == 0, "R4 reset iv", 128'(r), 0);

    // sweep: key sizes large to small leave stale upper key words
    for (int s = 2; s >= 0; s--) begin
      load_key(s);
      for (int m = 0; m < 5; m++)
        for (int d = 0; d < 2; d++) begin
          set_ctrl(m, d[0], s, 1);
          if (m != 0) load_iv({rnd(), rnd(), rnd(), rnd()});
          for (int b = 0; b < 2; b++)
            run({rnd(), rnd(), rnd(), rnd()},
                $sformatf("%s k%0d d%0d b%0d%s", nm[m], s, d, b, s < 2 ? " R2" : ""), 0);
        end
    end

    // counter wrap on low word
    set_ctrl(4, 0, 0, 1);
    load_iv({32'hA5A5_0000, 32'h0000_0001, 32'h7FFF_FFFF, 32'hFFFF_FFFF});
    run({rnd(), rnd(), rnd(), rnd()}, "R9 CTR wrap", 0);
    run({rnd(), rnd(), rnd(), rnd()}, "R9 CTR after wrap", 0);

    // refused configurations
    set_ctrl(5, 0, 0, 1);  run({rnd(), rnd(), rnd(), rnd()}, "R3 mode5", 0);
    set_ctrl(7, 1, 0, 1);  run({rnd(), rnd(), rnd(), rnd()}, "R3 mode7", 0);
    set_ctrl(1, 0, 3, 1);  run({rnd(), rnd(), rnd(), rnd()}, "R1 ksz3", 0);

    // key-valid gating on decryption
    set_ctrl(0, 0, 0, 0);
    load_key(0);
    set_ctrl(0, 1, 0, 0);  run({rnd(), rnd(), rnd(), rnd()}, "R12 ECB dec refused", 0);
    set_ctrl(1, 1, 0, 0);  run({rnd(), rnd(), rnd(), rnd()}, "R12 CBC dec refused", 0);
    set_ctrl(0, 0, 0, 0);  run({rnd(), rnd(), rnd(), rnd()}, "R12 enc ungated", 0);
    rd(0, r); chk(r[8] == 0, "R12 kv low", 128'(r[8]), 0);
    set_ctrl(3, 1, 0, 0);  run({rnd(), rnd(), rnd(), rnd()}, "R12 CFB dec ungated", 0);
    set_ctrl(0, 1, 0, 1);  run({rnd(), rnd(), rnd(), rnd()}, "R12 dec with prep", 0);
    rd(0, r); chk(r[8] == 1, "R12 kv set", 128'(r[8]), 1);
    set_ctrl(0, 1, 0, 0);  run({rnd(), rnd(), rnd(), rnd()}, "R12 dec kv held", 0);
    set_ctrl(0, 1, 1, 0);  run({rnd(), rnd(), rnd(), rnd()}, "R12 ksz change clears", 0);

    // writes while busy are dropped
    set_ctrl(1, 0, 0, 1);
    load_iv({rnd(), rnd(), rnd(), rnd()});
    lat = 16;
    run({rnd(), rnd(), rnd(), rnd()}, "R11 busy writes", 1);
    lat = 3;
    run({rnd(), rnd(), rnd(), rnd()}, "R11 key kept", 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule